// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator with Staged Update

This block produces one pulse-width-modulated output. An N-bit phase accumulator advances by a programmable step on every clock. The output period is therefore 2^N / step clocks, and the output frequency is step × f_clk / 2^N. On each clock the top eight accumulator bits are compared with an 8-bit threshold. The threshold is inverted: a larger value gives a shorter high time. Threshold 0 means nearly always high, and 255 means nearly always low.

Software reaches the block through one 32-bit control word on a plain write/read port. New step and threshold values sit in a staging register. Setting the update-request bit asks for the staged values to be copied into the active set. That copy happens when the accumulator next wraps, which is the start of the next output cycle. If the generator is stopped, the copy happens at once. The hardware clears the request bit when the copy is made.

A small sequencer controls the commit. Its states are:
- `S_OFF`: stopped, accumulator held at zero. A pending request commits here on the next clock.
- `S_RUN`: running, nothing pending.
- `S_HOLD`: running, a request is waiting for the wrap.

Its transitions are:
- `go`: `S_OFF` to `S_RUN`, when enable is set.
- `arm`: `S_RUN` to `S_HOLD`, when a request appears.
- `land`: `S_HOLD` to `S_RUN`, on the wrap that commits the request.
- `stop`: `S_RUN` or `S_HOLD` to `S_OFF`, when enable is cleared.

Top module: `pa_pwm`

## Requirements
- R1: The control word places enable at bit 31, the update request at bit 30, the step at bits 8 upward (STEP_W bits) and the threshold at bits 7:0. Bits between the step field and bit 30 read as 0.
- R2: Synchronous reset clears enable, the request bit, the staged and active fields and the accumulator. After reset, reads return 0 and the output is low.
- R3: While running, the output is high in exactly the cycles where the top 8 accumulator bits are greater than or equal to the active threshold.
- R4: While running, the accumulator adds the active step on every clock modulo 2^STEP_W, so the output repeats every 2^STEP_W / step clocks.
- R5: A write with bit 30 set, made while no request is pending, stores the step and threshold in staging and makes bit 30 read as 1 from the next cycle.
- R6: While running, a pending request commits only on the clock where the accumulator wraps. Bit 30 then reads 0.
- R7: While stopped, a pending request commits on the clock after it is seen, and bit 30 then reads 0.
- R8: While a request is pending, the step, threshold and update fields of a write are ignored. The enable bit of that write still takes effect.
- R9: Reads return the current enable bit, the request bit and the staged step and threshold.
- R10: Setting enable in the same write as the update request, or in a later write, gives the same output waveform for the new settings.
- R11: Clearing enable drives the output low from the next cycle. It also holds the accumulator at zero, so a later restart begins at phase zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Control word readback |
| pwm_out | output | 1 | PWM output |

## Verification
The bench builds the block with the default STEP_W of 16. It uses power-of-two steps between 256 and 8192, which gives exact output periods of 8 to 256 clocks. A full period can therefore be counted in a few dozen cycles, and a request can be held pending for a long stretch of a 256-clock period. This makes the wrap-only commit, the ignored writes during a pending request, and both enable orderings reachable in short runs.

// File: rtl/pa_pwm_pkg.sv
package pa_pwm_pkg;

    localparam int CW_W      = 32;
    localparam int EN_POS    = 31;
    localparam int UPD_POS   = 30;
    localparam int STEP_LSB  = 8;
    localparam int THR_W     = 8;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_RUN  = 2'd1,
        S_HOLD = 2'd2
    } pa_state_e;

endpackage

// File: rtl/pa_ctrl_reg.sv
module pa_ctrl_reg
    import pa_pwm_pkg::*;
#(
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CW_W-1:0]   wdata,
    input  logic              commit,
    output logic              en,
    output logic              pend,
    output logic [STEP_W-1:0] step_stg,
    output logic [THR_W-1:0]  thr_stg,
    output logic [CW_W-1:0]   rdata
);

    localparam int STEP_MSB = STEP_LSB + STEP_W - 1;

    logic [STEP_W-1:0] wr_step;
    logic [THR_W-1:0]  wr_thr;
    logic              wr_upd;
    logic              wr_en;
    logic              accept;

    assign wr_step = wdata[STEP_MSB:STEP_LSB];
    assign wr_thr  = wdata[THR_W-1:0];
    assign wr_upd  = wdata[UPD_POS];
    assign wr_en   = wdata[EN_POS];
    assign accept  = we && !pend;

    // enable is always writable
    always_ff @(posedge clk) begin
        if (rst) begin
            en <= 1'b0;
        end else if (we) begin
            en <= wr_en;
        end
    end

    // staged fields only when nothing is pending
    always_ff @(posedge clk) begin
        if (rst) begin
            step_stg <= '0;
            thr_stg  <= '0;
        end else if (accept) begin
            step_stg <= wr_step;
            thr_stg  <= wr_thr;
        end
    end

    // request flag: commit wins over a (blocked) write
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (commit) begin
            pend <= 1'b0;
        end else if (accept) begin
            pend <= wr_upd;
        end
    end

    always_comb begin
        rdata                     = '0;
        rdata[EN_POS]             = en;
        rdata[UPD_POS]            = pend;
        rdata[STEP_MSB:STEP_LSB]  = step_stg;
        rdata[THR_W-1:0]          = thr_stg;
    end

endmodule

// File: rtl/pa_seq_fsm.sv
module pa_seq_fsm
    import pa_pwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic pend,
    input  logic wrap,
    output logic run,
    output logic commit
);

    pa_state_e state_q;
    pa_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF: begin
                if (en) state_d = S_RUN;                 // go
            end
            S_RUN: begin
                if (!en)      state_d = S_OFF;           // stop
                else if (pend) state_d = S_HOLD;         // arm
            end
            S_HOLD: begin
                if (!en)      state_d = S_OFF;           // stop
                else if (wrap) state_d = S_RUN;          // land
            end
            default: state_d = S_OFF;
        endcase
    end

    always_comb begin
        run    = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            S_OFF: begin
                commit = pend;
            end
            S_RUN: begin
                run = en;
            end
            S_HOLD: begin
                run    = en;
                commit = pend && wrap;
            end
            default: begin
                run    = 1'b0;
                commit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pa_phase_core.sv
module pa_phase_core
    import pa_pwm_pkg::*;
#(
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              commit,
    input  logic [STEP_W-1:0] step_stg,
    input  logic [THR_W-1:0]  thr_stg,
    output logic              wrap,
    output logic [STEP_W-1:0] acc,
    output logic              pwm_out
);

    localparam int ACC_W = STEP_W;

    logic [STEP_W-1:0] step_act;
    logic [THR_W-1:0]  thr_act;
    logic [ACC_W:0]    sum;
    logic [THR_W-1:0]  phase_hi;

    assign sum      = {1'b0, acc} + {1'b0, step_act};
    assign wrap     = run && sum[ACC_W];
    assign phase_hi = acc[ACC_W-1 -: THR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            step_act <= '0;
            thr_act  <= '0;
        end else if (commit) begin
            step_act <= step_stg;
            thr_act  <= thr_stg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (run) begin
            acc <= sum[ACC_W-1:0];
        end else begin
            acc <= '0;
        end
    end

    assign pwm_out = run && (phase_hi >= thr_act);

endmodule

// File: rtl/pa_pwm.sv
module pa_pwm
    import pa_pwm_pkg::*;
#(
    parameter int STEP_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        pwm_out
);

    logic              en;
    logic              pend;
    logic              run;
    logic              commit;
    logic              wrap;
    logic [STEP_W-1:0] step_stg;
    logic [THR_W-1:0]  thr_stg;
    logic [STEP_W-1:0] acc_w;

    pa_ctrl_reg #(.STEP_W(STEP_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .commit   (commit),
        .en       (en),
        .pend     (pend),
        .step_stg (step_stg),
        .thr_stg  (thr_stg),
        .rdata    (cfg_rdata)
    );

    pa_seq_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .pend   (pend),
        .wrap   (wrap),
        .run    (run),
        .commit (commit)
    );

    pa_phase_core #(.STEP_W(STEP_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .commit   (commit),
        .step_stg (step_stg),
        .thr_stg  (thr_stg),
        .wrap     (wrap),
        .acc      (acc_w),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/pa_pwm_chk.sv
module pa_pwm_chk #(
    parameter int STEP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [31:0]       rd,
    input logic              pwm_out,
    input logic [STEP_W-1:0] acc
);

    // R11
    out_low_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !rd[31] |-> !pwm_out);

    // R7
    idle_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (rd[30] && !rd[31] && !$past(rd[31])) |=> !rd[30]);

    // R8
    staged_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (rd[30] && $past(rd[30])) |-> $stable(rd[29:0]));

    // R11
    acc_parked_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd[31] && !$past(rd[31])) |-> (acc == '0));

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (rd == 32'd0 && !pwm_out));

endmodule

bind pa_pwm pa_pwm_chk #(.STEP_W(STEP_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd      (cfg_rdata),
    .pwm_out (pwm_out),
    .acc     (acc_w)
);

// File: tb/pa_pwm_bench.sv
module pa_pwm_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pa_pwm #(.STEP_W(16)) u_pa_pwm (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pwm_out   (pwm_out)
    );

    // {step[15:0], threshold[7:0], expected high count per period[7:0]}
    localparam logic [31:0] VEC [6] = '{
        {16'd4096, 8'd128, 8'd8},
        {16'd4096, 8'd0,   8'd16},
        {16'd4096, 8'd255, 8'd0},
        {16'd4096, 8'd64,  8'd12},
        {16'd8192, 8'd96,  8'd5},
        {16'd2048, 8'd200, 8'd7}
    };

    function automatic logic [31:0] word(bit e, bit u, int step, int thr);
        return {e, u, 6'd0, step[15:0], thr[7:0]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_high(int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) cnt++;
        end
    endtask

    task automatic count_rise(int n, output int cnt);
        logic prev;
        cnt  = 0;
        prev = pwm_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out && !prev) cnt++;
            prev = pwm_out;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        int per;
        int step;
        int thr;

        // R2: reset state
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 rdata", cfg_rdata, 32'd0);
        chk("R2 out", {31'd0, pwm_out}, 32'd0);

        // R1: reserved bits read zero
        wr(32'h3F00_0000 | word(0, 1, 4096, 128));
        chk("R1 layout", cfg_rdata, word(0, 1, 4096, 128));
        idle(2);
        chk("R7 idle commit", {31'd0, cfg_rdata[30]}, 32'd0);

        // R3 R4 R9 R10: vector table, enable written after update
        foreach (VEC[k]) begin
            step = int'(VEC[k][31:16]);
            thr  = int'(VEC[k][15:8]);
            per  = 65536 / step;
            wr(word(0, 0, step, thr));
            wr(word(0, 1, step, thr));
            idle(2);
            wr(word(1, 0, step, thr));
            chk("R9 readback", cfg_rdata, word(1, 0, step, thr));
            idle(4);
            count_high(per, cnt);
            chk("R3 high count", cnt, {24'd0, VEC[k][7:0]});
        end

        // R4: period through rising edges
        wr(word(0, 1, 4096, 128));
        idle(2);
        wr(word(1, 0, 4096, 128));
        idle(3);
        count_rise(64, cnt);
        chk("R4 edges step 4096", cnt, 32'd4);
        wr(word(0, 1, 8192, 128));
        idle(2);
        wr(word(1, 0, 8192, 128));
        idle(3);
        count_rise(64, cnt);
        chk("R4 edges step 8192", cnt, 32'd8);

        // R10: enable in the same write as the update
        wr(word(0, 0, 4096, 0));
        idle(2);
        wr(word(1, 1, 4096, 64));
        idle(4);
        count_high(16, cnt);
        chk("R10 same-write enable", cnt, 32'd12);

        // R11: stop, then restart from phase zero
        wr(word(0, 1, 4096, 0));
        idle(2);
        wr(word(1, 0, 4096, 0));
        idle(3);
        chk("R11 running high", {31'd0, pwm_out}, 32'd1);
        wr(word(0, 0, 4096, 0));
        count_high(20, cnt);
        chk("R11 stopped low", cnt, 32'd0);
        wr(word(0, 1, 4096, 128));
        idle(2);
        wr(word(1, 0, 4096, 128));
        cnt = 0;
        while (!pwm_out && cnt < 40) begin
            cnt++;
            @(negedge clk);
        end
        chk("R11 restart phase", cnt, 32'd9);

        // R5 R6 R8: request waits for the wrap; blocked writes
        wr(word(0, 0, 256, 0));
        wr(word(0, 1, 256, 0));
        idle(2);
        wr(word(1, 0, 256, 0));
        idle(5);
        wr(word(1, 1, 4096, 128));
        chk("R5 pending visible", cfg_rdata, word(1, 1, 4096, 128));
        wr(word(1, 1, 8192, 10));
        chk("R8 fields ignored", cfg_rdata, word(1, 1, 4096, 128));
        idle(50);
        chk("R6 still pending", {31'd0, cfg_rdata[30]}, 32'd1);
        cnt = 0;
        while (cfg_rdata[30] && cnt < 300) begin
            cnt++;
            @(negedge clk);
        end
        chk("R6 cleared at wrap", cfg_rdata, word(1, 0, 4096, 128));
        idle(2);
        count_high(16, cnt);
        chk("R6 new settings", cnt, 32'd8);

        // R8 R7: enable accepted while pending, then immediate commit
        wr(word(0, 0, 256, 0));
        wr(word(0, 1, 256, 0));
        idle(2);
        wr(word(1, 0, 256, 0));
        idle(5);
        wr(word(1, 1, 4096, 32));
        wr(word(0, 0, 8192, 99));
        chk("R8 enable taken", cfg_rdata & 32'hBFFF_FFFF, word(0, 0, 4096, 32));
        chk("R11 out low", {31'd0, pwm_out}, 32'd0);
        idle(3);
        chk("R7 commit when off", cfg_rdata, word(0, 0, 4096, 32));

        // R2: reset mid-run
        wr(word(1, 1, 4096, 0));
        idle(4);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset rdata", cfg_rdata, 32'd0);
        chk("R2 reset out", {31'd0, pwm_out}, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule